// File: doc/BRIEF.md
# Input Event Log Queue

This block keeps a time-ordered log of input events for a host processor. Three producers feed it: a key matrix scanner (press and release), a general-purpose input transition detector, and a programmable logic output change detector. Each producer offers a 7-bit identifier together with a state bit. The block packs these into one byte per event and stores up to 16 bytes in a circular buffer.

The host sees a register-style read port. The byte on `host_rdata` is always the oldest stored event, or 0x00 when nothing is stored. Pulsing `host_rd` removes that byte. A live count, a "new event" interrupt and an "overflow" interrupt sit beside the storage. Each interrupt has its own write-one-to-clear strobe.

When producers offer events in the same cycle, a fixed priority decides which one is stored. Each losing producer keeps its event in a one-entry hold stage and offers it again on the next cycle.

Top module: `evtlog_fifo`

## Requirements
- R1: After reset, `evt_cnt` is 0, both interrupts are low and `host_rdata` is 0x00.
- R2: A stored byte has the state bit in bit 7 (1 = press/active, 0 = release/inactive) and the identifier in bits 6:0. Bytes leave in the order in which they were stored, whichever producer they came from.
- R3: A read strobe while the log is empty changes nothing: `evt_cnt` stays 0 and `host_rdata` stays 0x00.
- R4: `evt_cnt` equals the number of stored events, between 0 and 16. It changes on the clock edge after a push or a pop.
- R5: An event that arrives while 16 events are stored, with no read in the same cycle, is dropped. The stored events are kept, and `ovf_irq` is high from the next cycle on.
- R6: `evt_irq` is high in the cycle after any event is stored.
- R7: A clear strobe lowers its interrupt on the next edge. If an event is stored (for `evt_irq`) or dropped (for `ovf_irq`) in the same cycle, the set wins and the interrupt stays high.
- R8: When producers offer events in the same cycle, the key event is stored first, then the input event, then the logic event. Each loser is offered again on following cycles. If a producer offers a new event while its held event still loses, the new event is lost.
- R9: An offer with identifier 0 (the "no event" code) is ignored. Nothing is stored and `evt_irq` does not change.
- R10: A read and a stored push in the same cycle leave `evt_cnt` unchanged. This also applies when the log is full, where the incoming event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_evt_v | input | 1 | Key scanner offers an event |
| key_evt_id | input | 7 | Key event identifier |
| key_evt_st | input | 1 | Key state, 1 = pressed |
| gpi_evt_v | input | 1 | Input transition offered |
| gpi_evt_id | input | 7 | Input event identifier |
| gpi_evt_st | input | 1 | Input state, 1 = active |
| lgc_evt_v | input | 1 | Logic output change offered |
| lgc_evt_id | input | 7 | Logic event identifier |
| lgc_evt_st | input | 1 | Logic state, 1 = active |
| host_rd | input | 1 | Read strobe that removes the oldest event |
| clr_evt_irq | input | 1 | Write-one-to-clear for the event interrupt |
| clr_ovf_irq | input | 1 | Write-one-to-clear for the overflow interrupt |
| host_rdata | output | 8 | Oldest stored event, 0x00 when empty |
| evt_cnt | output | 5 | Number of stored events |
| evt_irq | output | 1 | New event interrupt flag |
| ovf_irq | output | 1 | Overflow interrupt flag |

## Verification
The hardest states to reach from the ports are the full log meeting an incoming event in the same cycle as a read, and the logic producer losing arbitration twice in a row while the other two producers keep pushing. Directed sequences fill the log to exactly 16 entries, push once more to raise the overflow flag, and then read and push together. Another directed step has all three producers fire at once. Long constrained-random runs with dense offers then produce chains of held events, and a bench model that tracks the hold stages of all three producers follows every byte.

// File: rtl/evtlog_pkg.sv
package evtlog_pkg;
   typedef enum int unsigned {
      SRC_KEY = 0,
      SRC_GPI = 1,
      SRC_LGC = 2
   } evt_src_e;
   localparam int unsigned NUM_SRC = 3;
endpackage

// File: rtl/evtlog_hold.sv
module evtlog_hold #(
   parameter int unsigned ENT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             live_v,
   input  logic [ENT_W-1:0] live_e,
   input  logic             grant,
   output logic             req,
   output logic [ENT_W-1:0] req_e
);
   logic             held_v;
   logic [ENT_W-1:0] held_e;

   assign req   = held_v | live_v;
   assign req_e = held_v ? held_e : live_e;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_v <= 1'b0;
         held_e <= '0;
      end else if (req && !grant) begin
         held_v <= 1'b1;
         held_e <= req_e;
      end else if (held_v && live_v) begin
         held_v <= 1'b1;
         held_e <= live_e;
      end else begin
         held_v <= 1'b0;
      end
   end

   // R8
   retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !grant) |=> (req && req_e == $past(req_e)));
endmodule

// File: rtl/evtlog_arb.sv
module evtlog_arb #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   logic found;

   always_comb begin
      grant = '0;
      found = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !found) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   // R8
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R8
   grant_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (grant != '0 && ((grant - 1'b1) & req) == '0));
endmodule

// File: rtl/evtlog_ring.sv
module evtlog_ring #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned ENT_W = 8,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [ENT_W-1:0] push_e,
   input  logic             pop_req,
   output logic [ENT_W-1:0] head_e,
   output logic [CNT_W-1:0] count,
   output logic             accept,
   output logic             drop
);
   localparam int unsigned     PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt;
   logic             pop;

   assign pop    = pop_req && (cnt != '0);
   assign accept = push && ((cnt != FULL) || pop);
   assign drop   = push && !accept;

   generate
      if (DEPTH == (1 << PTR_W)) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (accept) wr_ptr <= wr_nxt;
         if (pop)    rd_ptr <= rd_nxt;
         case ({accept, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr] <= push_e;
   end

   assign head_e = (cnt == '0) ? '0 : mem[rd_ptr];
   assign count  = cnt;

   // R4
   count_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL);
   // R4
   count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !pop_req) |=> count == $past(count) + 1'b1);
   // R3
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && count == '0 && !push) |=> (count == '0 && head_e == '0));
   // R10
   push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop_req && count != '0) |=> $stable(count));
   // R5
   drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> $stable(count));
endmodule

// File: rtl/evtlog_fifo.sv
module evtlog_fifo
   import evtlog_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned ID_W  = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       key_evt_v,
   input  logic [ID_W-1:0]            key_evt_id,
   input  logic                       key_evt_st,
   input  logic                       gpi_evt_v,
   input  logic [ID_W-1:0]            gpi_evt_id,
   input  logic                       gpi_evt_st,
   input  logic                       lgc_evt_v,
   input  logic [ID_W-1:0]            lgc_evt_id,
   input  logic                       lgc_evt_st,
   input  logic                       host_rd,
   input  logic                       clr_evt_irq,
   input  logic                       clr_ovf_irq,
   output logic [ID_W:0]              host_rdata,
   output logic [$clog2(DEPTH+1)-1:0] evt_cnt,
   output logic                       evt_irq,
   output logic                       ovf_irq
);
   localparam int unsigned ENT_W = ID_W + 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("evtlog_fifo: DEPTH must be at least 2");
      end
      if (ID_W < 2) begin : g_bad_id
         $error("evtlog_fifo: ID_W must be at least 2");
      end
   endgenerate

   logic [NUM_SRC-1:0] src_v, req, grant;
   logic [ENT_W-1:0]   src_e [NUM_SRC];
   logic [ENT_W-1:0]   req_e [NUM_SRC];
   logic [ENT_W-1:0]   push_e;
   logic               push, accept, drop;

   assign src_v[SRC_KEY] = key_evt_v && (key_evt_id != '0);
   assign src_v[SRC_GPI] = gpi_evt_v && (gpi_evt_id != '0);
   assign src_v[SRC_LGC] = lgc_evt_v && (lgc_evt_id != '0);
   assign src_e[SRC_KEY] = {key_evt_st, key_evt_id};
   assign src_e[SRC_GPI] = {gpi_evt_st, gpi_evt_id};
   assign src_e[SRC_LGC] = {lgc_evt_st, lgc_evt_id};

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         evtlog_hold #(.ENT_W(ENT_W)) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .live_v (src_v[s]),
            .live_e (src_e[s]),
            .grant  (grant[s]),
            .req    (req[s]),
            .req_e  (req_e[s])
         );
      end
   endgenerate

   evtlog_arb #(.N(NUM_SRC)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .grant (grant)
   );

   always_comb begin
      push_e = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (grant[s]) push_e = push_e | req_e[s];
      end
   end
   assign push = |grant;

   evtlog_ring #(.DEPTH(DEPTH), .ENT_W(ENT_W), .CNT_W(CNT_W)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .push_e  (push_e),
      .pop_req (host_rd),
      .head_e  (host_rdata),
      .count   (evt_cnt),
      .accept  (accept),
      .drop    (drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_irq <= 1'b0;
         ovf_irq <= 1'b0;
      end else begin
         evt_irq <= accept | (evt_irq & ~clr_evt_irq);
         ovf_irq <= drop   | (ovf_irq & ~clr_ovf_irq);
      end
   end

   // R6
   evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> evt_irq);
   // R5
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> ovf_irq);
   // R7
   evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_evt_irq && !accept) |=> !evt_irq);
   // R7
   ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ovf_irq && !drop) |=> !ovf_irq);
endmodule

// File: tb/evtlog_fifo_tb.sv
module evtlog_fifo_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       k_v = 0, g_v = 0, l_v = 0, k_st = 0, g_st = 0, l_st = 0;
   logic [6:0] k_id = 0, g_id = 0, l_id = 0;
   logic       rd = 0, ce = 0, co = 0;
   logic [7:0] rdata;
   logic [4:0] cnt;
   logic       eirq, oirq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0] mq [17];
   int         mcnt = 0;
   bit         mevt = 0, movf = 0;
   bit         mh_v [3];
   logic [7:0] mh_e [3];

   always #5 clk = ~clk;

   evtlog_fifo dut_i (
      .clk(clk), .rst_n(rst_n),
      .key_evt_v(k_v), .key_evt_id(k_id), .key_evt_st(k_st),
      .gpi_evt_v(g_v), .gpi_evt_id(g_id), .gpi_evt_st(g_st),
      .lgc_evt_v(l_v), .lgc_evt_id(l_id), .lgc_evt_st(l_st),
      .host_rd(rd), .clr_evt_irq(ce), .clr_ovf_irq(co),
      .host_rdata(rdata), .evt_cnt(cnt), .evt_irq(eirq), .ovf_irq(oirq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_head();
      return (mcnt > 0) ? mq[0] : 8'h00;
   endfunction

   task automatic model_update();
      bit         lv [3];
      logic [7:0] le [3];
      bit         rq [3];
      logic [7:0] re [3];
      int         g;
      bit         pop, psh, acc;
      lv[0] = k_v && (k_id != 0); le[0] = {k_st, k_id};
      lv[1] = g_v && (g_id != 0); le[1] = {g_st, g_id};
      lv[2] = l_v && (l_id != 0); le[2] = {l_st, l_id};
      g = -1;
      for (int s = 0; s < 3; s++) begin
         rq[s] = mh_v[s] || lv[s];
         re[s] = mh_v[s] ? mh_e[s] : le[s];
         if (rq[s] && g < 0) g = s;
      end
      for (int s = 0; s < 3; s++) begin
         if (rq[s] && g != s) begin
            mh_v[s] = 1; mh_e[s] = re[s];
         end else if (mh_v[s] && lv[s]) begin
            mh_v[s] = 1; mh_e[s] = le[s];
         end else begin
            mh_v[s] = 0;
         end
      end
      pop = rd && (mcnt > 0);
      psh = (g >= 0);
      acc = psh && ((mcnt < 16) || pop);
      if (pop) begin
         for (int i = 0; i < 16; i++) mq[i] = mq[i+1];
         mcnt--;
      end
      if (acc) begin
         mq[mcnt] = re[g];
         mcnt++;
      end
      mevt = acc || (mevt && !ce);
      movf = (psh && !acc) || (movf && !co);
   endtask

   task automatic compare_all();
      chk(cnt == mcnt[4:0], "R4 evt_cnt", int'(cnt), mcnt);
      chk(rdata == m_head(), "R2 host_rdata", int'(rdata), int'(m_head()));
      chk(eirq == mevt, "R6 evt_irq", int'(eirq), int'(mevt));
      chk(oirq == movf, "R5 ovf_irq", int'(oirq), int'(movf));
   endtask

   task automatic step();
      model_update();
      @(posedge clk);
      #1;
      compare_all();
      k_v = 0; g_v = 0; l_v = 0; k_id = 0; g_id = 0; l_id = 0;
      k_st = 0; g_st = 0; l_st = 0; rd = 0; ce = 0; co = 0;
   endtask

   task automatic key_push(input logic [6:0] id);
      k_v = 1; k_id = id; k_st = 1;
      step();
   endtask

   initial begin
      void'($urandom(32'h00C0FFEE));
      for (int s = 0; s < 3; s++) begin mh_v[s] = 0; mh_e[s] = 0; end
      for (int i = 0; i < 17; i++) mq[i] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(cnt == 0, "R1 evt_cnt", int'(cnt), 0);
      chk(rdata == 8'h00, "R1 host_rdata", int'(rdata), 0);
      chk(!eirq && !oirq, "R1 irqs", int'({eirq, oirq}), 0);

      // R8 all three producers at once
      k_v = 1; k_id = 7'h05; k_st = 1;
      g_v = 1; g_id = 7'h30; g_st = 0;
      l_v = 1; l_id = 7'h50; l_st = 1;
      step();
      chk(cnt == 1 && rdata == 8'h85, "R8 key first", int'(rdata), 8'h85);
      step();
      step();
      chk(cnt == 3, "R8 all stored", int'(cnt), 3);
      rd = 1; step();
      chk(rdata == 8'h30, "R8 gpi second", int'(rdata), 8'h30);
      rd = 1; step();
      chk(rdata == 8'hD0, "R8 logic third", int'(rdata), 8'hD0);
      rd = 1; step();
      // R3 read on empty
      rd = 1; step();
      chk(cnt == 0 && rdata == 8'h00, "R3 empty read", int'(rdata), 0);

      // R7 clear both
      ce = 1; co = 1; step();
      chk(!eirq, "R7 evt clear", int'(eirq), 0);
      // R9 identifier zero ignored
      k_v = 1; k_id = 0; k_st = 1; step();
      chk(cnt == 0 && !eirq, "R9 id zero", int'(cnt), 0);
      // R7 set wins over clear
      k_v = 1; k_id = 7'h01; k_st = 1; ce = 1; step();
      chk(eirq, "R7 set wins", int'(eirq), 1);

      // R5 fill to 16 and overflow
      for (int i = 2; i <= 16; i++) key_push(7'(i));
      chk(cnt == 16, "R4 full count", int'(cnt), 16);
      key_push(7'h7F);
      chk(cnt == 16 && oirq, "R5 overflow", int'(cnt), 16);
      chk(rdata == 8'h81, "R5 head kept", int'(rdata), 8'h81);
      // R10 read and push while full
      k_v = 1; k_id = 7'h11; k_st = 1; rd = 1; step();
      chk(cnt == 16 && rdata == 8'h82, "R10 push+pop full", int'(rdata), 8'h82);
      for (int i = 0; i < 16; i++) begin rd = 1; step(); end
      rd = 1; step();
      chk(cnt == 0 && rdata == 8'h00, "R3 drained", int'(rdata), 0);
      co = 1; ce = 1; step();

      // random phase
      for (int n = 0; n < 4000; n++) begin
         k_v = ($urandom % 100) < 30; k_id = 7'($urandom); k_st = 1'($urandom);
         g_v = ($urandom % 100) < 30; g_id = 7'($urandom); g_st = 1'($urandom);
         l_v = ($urandom % 100) < 30; l_id = 7'($urandom); l_st = 1'($urandom);
         rd = ($urandom % 100) < ((n % 1000) < 500 ? 25 : 60);
         ce = ($urandom % 100) < 8;
         co = ($urandom % 100) < 8;
         step();
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule